// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This controller brings a set of supply rails (four by default) up one after another and takes them down in the opposite order. Start-up needs two things: every undervoltage-lockout flag reports good and the active-low enable is held low. A fixed lockout interval then runs, and after it a programmable delay before each rail's enable output rises. The next rail's delay starts only after the previous rail reports that it has reached full level. A long hold-off follows the last rail. The active-low reset output is released only when that hold-off has run out.

Raising the enable starts turn-off with no lockout. The top rail drops first after its own off-delay. Each lower rail waits until the rail above it reports that it is below its low threshold, and then runs its own off-delay. An undervoltage fault, or a low level on the shared open-drain system-reset line, drops every rail and the reset output on the next clock. The system-reset line is modelled as a sensed level plus a pull-down drive. The controller pulls the line down only when a fault appears after a completed start-up and lasts longer than a filter time. This lets several controllers share one kill line. A rising edge on that line while all start conditions hold skips the lockout. This gives an automatic restart once a fault clears. All durations are counts of clock ticks.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, `rail_en` is all zero, `reset_n` is 0 and `sysrst_drive_low` is 0. No rail enable rises while `en_n` is 1 or any bit of `uv_good` is 0.
- R2: When `en_n` falls with all `uv_good` bits at 1 and `sysrst_in` at 1, `rail_en[0]` rises LOCKOUT_TICKS + `dly_on[0]` + 3 clock cycles later.
- R3: Rails turn on in ascending index order, and at most one enable changes per cycle during normal sequencing. `rail_en[i+1]` rises `dly_on[i+1]` + 2 cycles after `rail_full[i]` rises.
- R4: `reset_n` rises HOLDOFF_TICKS + 2 cycles after `rail_full` of the top rail rises. `reset_n` is 1 only while every rail is enabled.
- R5: When `en_n` rises after start-up, `reset_n` falls one cycle later and the top rail's enable falls `dly_off[top]` + 2 cycles later. Each lower rail `i` falls `dly_off[i]` + 2 cycles after `rail_low[i+1]` rises. `rail_en` always reads as a thermometer code (bit i+1 set only if bit i is set).
- R6: Any `uv_good` bit at 0 clears all of `rail_en` and `reset_n` on the next clock edge.
- R7: `sysrst_in` at 0 clears all of `rail_en` and `reset_n` on the next clock edge. No rail starts while it stays at 0.
- R8: A rising edge on `sysrst_in` with `en_n` at 0 and all `uv_good` at 1 skips the lockout, and `rail_en[0]` rises `dly_on[0]` + 2 cycles after the edge.
- R9: Take a fault that begins while `reset_n` is 1. If it lasts FILTER_TICKS + 1 cycles, `sysrst_drive_low` is asserted FILTER_TICKS + 1 cycles after the fault appears and is held while any `uv_good` bit stays 0. A fault that clears sooner never asserts it.
- R10: After a fault clears, the controller starts up again with no other action and reaches `reset_n` at 1.
- R11: A delay value of zero gives a 2-cycle step between the triggering event and the enable change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timers count its ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low sequence enable |
| uv_good | input | NUM_RAILS | Undervoltage-lockout good flag per supply |
| rail_full | input | NUM_RAILS | Rail has reached full level |
| rail_low | input | NUM_RAILS | Rail is below its low threshold |
| dly_on | input | NUM_RAILS x DLY_W | Per-rail turn-on delay in ticks |
| dly_off | input | NUM_RAILS x DLY_W | Per-rail turn-off delay in ticks |
| sysrst_in | input | 1 | Sensed level of the shared system-reset line |
| rail_en | output | NUM_RAILS | Rail enable outputs |
| reset_n | output | 1 | Active-low reset output |
| sysrst_drive_low | output | 1 | Pull-down drive for the shared system-reset line |

## Verification
A wrong sequencer state or a wrong rail index shows as an enable edge that lands on the wrong cycle or on the wrong bit, so the exact gaps between feedback edges and enable edges expose it within one rail step. A timer that is loaded with the wrong value or that stops early shifts these gaps by a measurable number of cycles during the lockout, the per-rail delays or the hold-off. A filter that counts wrongly shows at the pull-down drive within FILTER_TICKS + 2 cycles of a fault. A lost edge detector shows as a start that takes the full lockout instead of skipping it.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOCK,
        S_UP_DLY,
        S_UP_WAIT,
        S_HOLD,
        S_RUN,
        S_DN_DLY,
        S_DN_WAIT
    } seq_state_e;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/uv_kill_filter.sv
module uv_kill_filter #(
    parameter int FILTER_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seq_done,
    input  logic uv_bad,
    output logic drive_low
);
    localparam int FW = $clog2(FILTER_TICKS + 1) + 1;

    typedef struct packed {
        logic [FW-1:0] cnt;
        logic          armed;
        logic          drive;
    } flt_t;

    flt_t d, q;
    logic active, fire;

    always_comb begin
        d      = q;
        active = seq_done || q.armed;
        fire   = !q.drive && active && uv_bad && (q.cnt >= FW'(FILTER_TICKS));
        if (active && uv_bad)
            d.cnt = (q.cnt >= FW'(FILTER_TICKS)) ? q.cnt : q.cnt + FW'(1);
        else
            d.cnt = '0;
        if (seq_done)
            d.armed = 1'b1;
        else if (fire || !uv_bad)
            d.armed = 1'b0;
        d.drive = q.drive ? uv_bad : fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign drive_low = q.drive;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NUM_RAILS     = 4,
    parameter int DLY_W         = 16,
    parameter int LOCKOUT_TICKS = 2_500_000,
    parameter int HOLDOFF_TICKS = 40_000_000,
    parameter int FILTER_TICKS  = 250
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             en_n,
    input  logic [NUM_RAILS-1:0]             uv_good,
    input  logic [NUM_RAILS-1:0]             rail_full,
    input  logic [NUM_RAILS-1:0]             rail_low,
    input  logic [NUM_RAILS-1:0][DLY_W-1:0]  dly_on,
    input  logic [NUM_RAILS-1:0][DLY_W-1:0]  dly_off,
    input  logic                             sysrst_in,
    output logic [NUM_RAILS-1:0]             rail_en,
    output logic                             reset_n,
    output logic                             sysrst_drive_low
);
    localparam int IDX_W  = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1;
    localparam int DLY_MX = (1 << DLY_W) - 1;
    localparam int MAX_A  = (LOCKOUT_TICKS > HOLDOFF_TICKS) ? LOCKOUT_TICKS : HOLDOFF_TICKS;
    localparam int MAX_T  = (MAX_A > DLY_MX) ? MAX_A : DLY_MX;
    localparam int CNT_W  = $clog2(MAX_T + 1);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_RAILS - 1);

    typedef struct packed {
        seq_state_e           state;
        logic [IDX_W-1:0]     idx;
        logic [NUM_RAILS-1:0] en;
        logic                 rst_out;
        logic                 sys_prev;
    } seq_t;

    seq_t d, q;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic             uv_bad, ready, sys_rise;

    assign uv_bad   = !(&uv_good);
    assign ready    = !uv_bad && !en_n;
    assign sys_rise = sysrst_in && !q.sys_prev;

    always_comb begin
        d          = q;
        d.sys_prev = sysrst_in;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        if (uv_bad || !sysrst_in) begin
            d.state   = S_IDLE;
            d.en      = '0;
            d.rst_out = 1'b0;
        end else begin
            case (q.state)
                S_IDLE, S_LOCK: begin
                    if (en_n) begin
                        d.state = S_IDLE;
                    end else if (ready && sys_rise) begin
                        d.state  = S_UP_DLY;
                        d.idx    = '0;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(dly_on[0]);
                    end else if (q.state == S_IDLE) begin
                        d.state  = S_LOCK;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(LOCKOUT_TICKS);
                    end else if (tmr_zero) begin
                        d.state  = S_UP_DLY;
                        d.idx    = '0;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(dly_on[0]);
                    end
                end
                S_UP_DLY: begin
                    if (en_n) begin
                        if (q.idx == '0) begin
                            d.state = S_IDLE;
                        end else begin
                            d.state  = S_DN_DLY;
                            d.idx    = q.idx - IDX_W'(1);
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(dly_off[q.idx - IDX_W'(1)]);
                        end
                    end else if (tmr_zero) begin
                        d.state       = S_UP_WAIT;
                        d.en[q.idx]   = 1'b1;
                    end
                end
                S_UP_WAIT: begin
                    if (en_n) begin
                        d.state  = S_DN_DLY;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(dly_off[q.idx]);
                    end else if (rail_full[q.idx]) begin
                        tmr_load = 1'b1;
                        if (q.idx == TOP) begin
                            d.state = S_HOLD;
                            tmr_val = CNT_W'(HOLDOFF_TICKS);
                        end else begin
                            d.state = S_UP_DLY;
                            d.idx   = q.idx + IDX_W'(1);
                            tmr_val = CNT_W'(dly_on[q.idx + IDX_W'(1)]);
                        end
                    end
                end
                S_HOLD, S_RUN: begin
                    if (en_n) begin
                        d.state   = S_DN_DLY;
                        d.idx     = TOP;
                        d.rst_out = 1'b0;
                        tmr_load  = 1'b1;
                        tmr_val   = CNT_W'(dly_off[TOP]);
                    end else if (q.state == S_HOLD && tmr_zero) begin
                        d.state   = S_RUN;
                        d.rst_out = 1'b1;
                    end
                end
                S_DN_DLY: begin
                    if (tmr_zero) begin
                        d.state     = S_DN_WAIT;
                        d.en[q.idx] = 1'b0;
                    end
                end
                S_DN_WAIT: begin
                    if (rail_low[q.idx]) begin
                        if (q.idx == '0) begin
                            d.state = S_IDLE;
                        end else begin
                            d.state  = S_DN_DLY;
                            d.idx    = q.idx - IDX_W'(1);
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(dly_off[q.idx - IDX_W'(1)]);
                        end
                    end
                end
                default: d.state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: S_IDLE, idx: '0, en: '0, rst_out: 1'b0, sys_prev: 1'b1};
        else        q <= d;
    end

    seq_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    uv_kill_filter #(.FILTER_TICKS(FILTER_TICKS)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_done  (q.rst_out),
        .uv_bad    (uv_bad),
        .drive_low (sysrst_drive_low)
    );

    assign rail_en = q.en;
    assign reset_n = q.rst_out;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
    parameter int NUM_RAILS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RAILS-1:0] uv_good,
    input logic                 sysrst_in,
    input logic [NUM_RAILS-1:0] rail_en,
    input logic                 reset_n,
    input logic                 sysrst_drive_low
);
    AST_RESET_NEEDS_ALL_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
        reset_n |-> (&rail_en)); // R4

    AST_UV_FAULT_DROPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(&uv_good) |=> (rail_en == '0) && !reset_n); // R6

    AST_KILL_DROPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !sysrst_in |=> (rail_en == '0) && !reset_n); // R7

    AST_DRIVE_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        sysrst_drive_low |-> $past(!(&uv_good))); // R9

    AST_ONE_RAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((&uv_good) && sysrst_in) |=> $onehot0(rail_en ^ $past(rail_en))); // R3

    AST_THERMOMETER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ((rail_en + NUM_RAILS'(1)) & rail_en) == '0); // R5
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.NUM_RAILS(NUM_RAILS)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .uv_good          (uv_good),
    .sysrst_in        (sysrst_in),
    .rail_en          (rail_en),
    .reset_n          (reset_n),
    .sysrst_drive_low (sysrst_drive_low)
);

// File: tb/tb_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_seq_ctrl;
    localparam int N = 4;
    localparam int DW = 8;
    localparam int LK = 20;
    localparam int HO = 30;
    localparam int FT = 5;
    localparam int ROWS = 3;
    // row: on delays for rails 0..3, then off delays for rails 0..3
    localparam logic [7:0] DLY_TBL [0:ROWS-1][0:7] = '{
        '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
        '{8'd3, 8'd1, 8'd4, 8'd2, 8'd5, 8'd0, 8'd2, 8'd7},
        '{8'd6, 8'd2, 8'd0, 8'd9, 8'd1, 8'd8, 8'd3, 8'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, en_n = 1'b1, ext_kill = 1'b0, done = 1'b0;
    logic [N-1:0] uv_good = '1;
    logic [N-1:0] rail_full, rail_low, rail_en;
    logic [N-1:0][DW-1:0] dly_on = '0, dly_off = '0;
    logic sysrst_in, reset_n, sysrst_drive_low;
    logic [N-1:0] p0, p1, p2;
    int tests = 0, fails = 0, cyc = 0;
    int ton [N], toff [N], tfull [N], tlow [N];
    int trst_up = 0, trst_dn = 0;
    logic [N-1:0] pen = '0, pfull = '0, plow = '1;
    logic prst = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign sysrst_in = !(ext_kill || sysrst_drive_low);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin p0 <= '0; p1 <= '0; p2 <= '0; end
        else begin p0 <= rail_en; p1 <= p0; p2 <= p1; end
    end
    assign rail_full = p2;
    assign rail_low  = ~p2;

    pwr_seq_ctrl #(.NUM_RAILS(N), .DLY_W(DW), .LOCKOUT_TICKS(LK),
                   .HOLDOFF_TICKS(HO), .FILTER_TICKS(FT)) dut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .uv_good(uv_good),
        .rail_full(rail_full), .rail_low(rail_low), .dly_on(dly_on),
        .dly_off(dly_off), .sysrst_in(sysrst_in), .rail_en(rail_en),
        .reset_n(reset_n), .sysrst_drive_low(sysrst_drive_low));

    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rail_en[i] && !pen[i])     ton[i]   = cyc;
            if (!rail_en[i] && pen[i])     toff[i]  = cyc;
            if (rail_full[i] && !pfull[i]) tfull[i] = cyc;
            if (rail_low[i] && !plow[i])   tlow[i]  = cyc;
        end
        if (reset_n && !prst) trst_up = cyc;
        if (!reset_n && prst) trst_dn = cyc;
        pen = rail_en; pfull = rail_full; plow = rail_low; prst = reset_n;
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_reset_up();
        for (int n = 0; n < 3000 && !reset_n; n++) @(negedge clk);
    endtask

    task automatic wait_all_low();
        for (int n = 0; n < 3000 && (rail_en != '0 || rail_low != '1); n++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int t0, z, hit;
        repeat (3) @(negedge clk);
        chk("R1 reset rail_en", int'(rail_en), 0);
        chk("R1 reset reset_n", int'(reset_n), 0);
        chk("R1 reset drive", int'(sysrst_drive_low), 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk("R1 en_n high no start", int'(rail_en), 0);
        uv_good = 4'b1011; en_n = 1'b0;
        repeat (40) @(negedge clk);
        chk("R1 uv bad no start", int'(rail_en), 0);
        en_n = 1'b1; uv_good = '1;
        repeat (3) @(negedge clk);

        for (int r = 0; r < ROWS; r++) begin
            for (int i = 0; i < N; i++) begin
                dly_on[i]  = DLY_TBL[r][i];
                dly_off[i] = DLY_TBL[r][i+4];
            end
            t0 = cyc; en_n = 1'b0;
            wait_reset_up();
            repeat (4) @(negedge clk);
            chk("R2 lockout to rail0", ton[0] - t0, LK + int'(DLY_TBL[r][0]) + 3);
            for (int i = 0; i < N-1; i++)
                chk((DLY_TBL[r][i+1] == 0) ? "R3 R11 on step" : "R3 on step",
                    ton[i+1] - tfull[i], int'(DLY_TBL[r][i+1]) + 2);
            chk("R4 hold-off", trst_up - tfull[N-1], HO + 2);
            t0 = cyc; en_n = 1'b1;
            wait_all_low();
            chk("R5 reset drop", trst_dn - t0, 1);
            chk((DLY_TBL[r][7] == 0) ? "R5 R11 top off" : "R5 top off",
                toff[N-1] - t0, int'(DLY_TBL[r][7]) + 2);
            for (int i = N-2; i >= 0; i--)
                chk((DLY_TBL[r][i+4] == 0) ? "R5 R11 off step" : "R5 off step",
                    toff[i] - tlow[i+1], int'(DLY_TBL[r][i+4]) + 2);
        end

        // kill held low blocks start; release bypasses lockout
        ext_kill = 1'b1; en_n = 1'b0;
        repeat (40) @(negedge clk);
        chk("R7 held kill no start", int'(rail_en), 0);
        t0 = cyc; ext_kill = 1'b0;
        wait_reset_up();
        chk("R8 bypass to rail0", ton[0] - t0, int'(DLY_TBL[ROWS-1][0]) + 2);

        // kill during run
        ext_kill = 1'b1;
        @(negedge clk);
        chk("R7 kill rails", int'(rail_en), 0);
        chk("R7 kill reset_n", int'(reset_n), 0);
        ext_kill = 1'b0;
        wait_reset_up();
        chk("R10 restart after kill", int'(reset_n), 1);

        // long undervoltage fault
        uv_good = 4'b1101;
        @(negedge clk);
        chk("R6 uv rails", int'(rail_en), 0);
        chk("R6 uv reset_n", int'(reset_n), 0);
        repeat (FT-1) @(negedge clk);
        chk("R9 not before filter", int'(sysrst_drive_low), 0);
        @(negedge clk);
        chk("R9 drive after filter", int'(sysrst_drive_low), 1);
        repeat (10) @(negedge clk);
        chk("R9 drive held", int'(sysrst_in), 0);
        uv_good = '1;
        @(negedge clk);
        chk("R9 drive released", int'(sysrst_drive_low), 0);
        wait_reset_up();
        chk("R10 restart after fault", int'(reset_n), 1);
        chk("R10 all rails up", int'(rail_en), 15);

        // short glitch shorter than the filter
        uv_good = 4'b0111;
        repeat (2) @(negedge clk);
        uv_good = '1;
        hit = 0;
        for (z = 0; z < 15; z++) begin
            @(negedge clk);
            if (sysrst_drive_low) hit = 1;
        end
        chk("R9 short glitch no drive", hit, 0);
        wait_reset_up();
        chk("R10 restart after glitch", int'(reset_n), 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule